// File: doc/BRIEF.md
# Wrapping burst memory slave

This block is the target side of a synchronous processor bus. It serves reads and writes to a small internal word store. An access opens when the master raises a start strobe while the slave is idle. A burst covers one 16-byte aligned block, and it may begin at any word or halfword of that block. The slave keeps its own position counter, because the bus address stays constant for the whole burst. The counter advances after every beat and folds back to the start of the block after the last position.

Each beat ends with a one-cycle acknowledge pulse. Read data is valid in the acknowledge cycle, and write data is taken at the clock edge that closes it. The master controls how long the burst runs with a "more beats" flag. As a safety stop, the slave ends the burst once the block is exhausted. The slave can also be set to refuse bursts: it then raises an inhibit flag with the first acknowledge and serves only that word.

For slow-slave timing, a wait count of 0 to 3 cycles is added before every acknowledge. A halfword port mode moves 16 bits per beat and makes eight beats per block.

Top module: `burst_slave`

## Requirements
- R1: After reset, `ack` and `inhibit` are low and every location of the store reads as zero.
- R2: A start strobe seen in idle captures the address, direction, burst flag, port mode, wait count and refuse setting. Later changes to these inputs have no effect until the access ends.
- R3: In word mode the position is address bits [3:2] and the block is the address bits above bit 3. Each beat moves to the next word, and word 3 is followed by word 0 of the same block.
- R4: In halfword mode the position is address bits [3:1] and runs through 8 values, with 7 followed by 0. Halfword h sits in word h>>1, in bits [15:0] when h is even and in bits [31:16] when h is odd. Reads return it on `rdata[15:0]` with the upper half zero. Writes take `wdata[15:0]`.
- R5: Every beat is acknowledged by a single-cycle `ack` after `wait_cfg` extra cycles. The first `ack` falls in cycle wait+1 after the start edge. Each later one falls wait+1 cycles after the previous `ack`.
- R6: During a read `ack` cycle, `rdata` holds the addressed data. A write stores `wdata` as sampled at the edge that ends the `ack` cycle.
- R7: A beat is the last one if `more_beats` is low at the edge that ends its `ack` cycle, or if it was low at any earlier edge since the start edge.
- R8: A burst never runs past 4 beats in word mode or 8 beats in halfword mode.
- R9: A start with `burst_req` low is acknowledged exactly once.
- R10: With `refuse_burst` set, a burst request gets one beat whose `ack` carries `inhibit`. A single-beat access never raises `inhibit`.
- R11: The slave is idle in the cycle after the final `ack`, and a start strobe in that cycle is accepted.
- R12: A start strobe while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Start strobe for a new access |
| burst_req | input | 1 | High: burst; low: single beat |
| write_req | input | 1 | High: write; low: read |
| half_port | input | 1 | High: 16-bit beats |
| addr | input | AW-1 | Byte address bits AW-1 down to 1 |
| wdata | input | DW | Write data |
| more_beats | input | 1 | Master wants another beat after the current one |
| wait_cfg | input | 2 | Wait cycles before each acknowledge |
| refuse_burst | input | 1 | Slave declines bursts |
| ack | output | 1 | Beat acknowledge |
| inhibit | output | 1 | Burst refused, valid with `ack` |
| rdata | output | DW | Read data, valid with `ack` on reads |

## Verification
The properties assume the master keeps `more_beats` meaningful on every edge of an access. A stray start strobe during an access must be harmless. The stimulus obeys both: `more_beats` is recomputed each cycle from the number of beats still wanted, and start pulses during a burst are injected on purpose. All inputs change on the falling edge, so each rising edge sees stable values. Address and attribute inputs are deliberately scrambled after the start edge, so anything that reads them late would diverge from the reference model.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } st_t;

    localparam int IDXW   = 3;   // halfword position inside a block
    localparam int WAITW  = 2;   // wait-state count width

endpackage

// File: rtl/bst_wrap_step.sv
module bst_wrap_step
    import burst_pkg::*;
(
    input  logic [IDXW-1:0] idx,
    input  logic [IDXW-1:0] beats,
    input  logic            half,
    output logic [IDXW-1:0] idx_next,
    output logic            cap_hit
);

    localparam logic [IDXW-1:0] LAST_WORD = IDXW'(3);
    localparam logic [IDXW-1:0] LAST_HALF = IDXW'(7);

    logic [1:0] word_pos_nx;

    always_comb begin
        word_pos_nx = idx[1:0] + 2'd1;
        if (half) begin
            idx_next = idx + IDXW'(1);
            cap_hit  = (beats == LAST_HALF);
        end else begin
            idx_next = {1'b0, word_pos_nx};
            cap_hit  = (beats == LAST_WORD);
        end
    end

endmodule

// File: rtl/bst_wait_timer.sv
module bst_wait_timer
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WAITW-1:0] load_val,
    input  logic             run,
    output logic             expire
);

    logic [WAITW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - WAITW'(1);
        end
        expire = (cnt_q == WAITW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/bst_word_store.sv
module bst_word_store #(
    parameter int NW  = 16,
    parameter int DW  = 32,
    parameter int WAW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [WAW-1:0] waddr,
    input  logic           half,
    input  logic           hsel,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata
);

    localparam int HW = DW / 2;

    typedef struct packed {
        logic [NW-1:0][DW-1:0] mem;
    } store_t;

    store_t s_d, s_q;
    logic [DW-1:0] word_rd;

    always_comb begin
        s_d     = s_q;
        word_rd = s_q.mem[waddr];
        if (we) begin
            if (!half) begin
                s_d.mem[waddr] = wdata;
            end else if (hsel) begin
                s_d.mem[waddr][DW-1:HW] = wdata[HW-1:0];
            end else begin
                s_d.mem[waddr][HW-1:0] = wdata[HW-1:0];
            end
        end
        if (!half) begin
            rdata = word_rd;
        end else if (hsel) begin
            rdata = {{HW{1'b0}}, word_rd[DW-1:HW]};
        end else begin
            rdata = {{HW{1'b0}}, word_rd[HW-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/burst_slave.sv
module burst_slave
    import burst_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_start,
    input  logic          burst_req,
    input  logic          write_req,
    input  logic          half_port,
    input  logic [AW-1:1] addr,
    input  logic [DW-1:0] wdata,
    input  logic          more_beats,
    input  logic [1:0]    wait_cfg,
    input  logic          refuse_burst,
    output logic          ack,
    output logic          inhibit,
    output logic [DW-1:0] rdata
);

    localparam int BW  = AW - 4;        // block number width
    localparam int WAW = AW - 2;        // word address width
    localparam int NW  = 2 ** WAW;      // words in the store

    typedef struct packed {
        st_t              st;
        logic [BW-1:0]    base;
        logic [IDXW-1:0]  idx;
        logic [IDXW-1:0]  beats;
        logic [WAITW-1:0] wcfg;
        logic             wr;
        logic             bur;
        logic             half;
        logic             refuse;
        logic             fin;
    } ctl_t;

    localparam ctl_t CTL_RST = '0;

    ctl_t q, d;

    logic [IDXW-1:0]  idx_nx;
    logic             cap_hit;
    logic             tmr_load;
    logic [WAITW-1:0] tmr_val;
    logic             tmr_run;
    logic             tmr_expire;
    logic             last_beat;
    logic             st_we;
    logic [WAW-1:0]   st_addr;
    logic             st_hsel;

    // observation points for the bound checker
    logic             busy;
    logic             bursting;
    logic             half_act;

    bst_wrap_step u_wrap (
        .idx      (q.idx),
        .beats    (q.beats),
        .half     (q.half),
        .idx_next (idx_nx),
        .cap_hit  (cap_hit)
    );

    bst_wait_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expire   (tmr_expire)
    );

    bst_word_store #(
        .NW  (NW),
        .DW  (DW),
        .WAW (WAW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (st_addr),
        .half  (q.half),
        .hsel  (st_hsel),
        .wdata (wdata),
        .rdata (rdata)
    );

    always_comb begin
        d         = q;
        tmr_load  = 1'b0;
        tmr_val   = wait_cfg;
        tmr_run   = 1'b0;
        last_beat = !q.bur || q.refuse || q.fin || !more_beats || cap_hit;

        unique case (q.st)
            ST_IDLE: begin
                if (xfer_start) begin
                    d.base   = addr[AW-1:4];
                    d.idx    = half_port ? addr[3:1] : {1'b0, addr[3:2]};
                    d.beats  = '0;
                    d.wcfg   = wait_cfg;
                    d.wr     = write_req;
                    d.bur    = burst_req;
                    d.half   = half_port;
                    d.refuse = refuse_burst;
                    d.fin    = !more_beats;
                    tmr_load = 1'b1;
                    tmr_val  = wait_cfg;
                    d.st     = (wait_cfg == '0) ? ST_ACK : ST_WAIT;
                end
            end
            ST_WAIT: begin
                tmr_run = 1'b1;
                d.fin   = q.fin | !more_beats;
                if (tmr_expire) begin
                    d.st = ST_ACK;
                end
            end
            ST_ACK: begin
                if (last_beat) begin
                    d.st = ST_IDLE;
                end else begin
                    d.idx    = idx_nx;
                    d.beats  = q.beats + IDXW'(1);
                    tmr_load = 1'b1;
                    tmr_val  = q.wcfg;
                    d.st     = (q.wcfg == '0) ? ST_ACK : ST_WAIT;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ack      = (q.st == ST_ACK);
        inhibit  = ack && q.bur && q.refuse;
        st_we    = ack && q.wr;
        st_addr  = {q.base, (q.half ? q.idx[2:1] : q.idx[1:0])};
        st_hsel  = q.half & q.idx[0];
        busy     = (q.st != ST_IDLE);
        bursting = q.bur;
        half_act = q.half;
    end

endmodule

// File: rtl/burst_slave_chk.sv
module burst_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_start,
    input logic more_beats,
    input logic ack,
    input logic inhibit,
    input logic busy,
    input logic bursting,
    input logic half_act
);

    logic [3:0] acks_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acks_seen <= '0;
        end else if (!busy && xfer_start) begin
            acks_seen <= '0;
        end else if (ack) begin
            acks_seen <= acks_seen + 4'd1;
        end
    end

    p_inhibit_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> ack);

    p_refuse_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !busy);

    p_single_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !bursting) |=> !busy);

    p_drop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !more_beats) |=> !busy);

    p_no_ack_unstarted_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !xfer_start) |=> !ack);

    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && xfer_start) |=> busy);

    p_beat_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (acks_seen < (half_act ? 4'd8 : 4'd4)));

endmodule

bind burst_slave burst_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .more_beats (more_beats),
    .ack        (ack),
    .inhibit    (inhibit),
    .busy       (busy),
    .bursting   (bursting),
    .half_act   (half_act)
);

// File: tb/burst_slave_tb.sv
module burst_slave_tb;

    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer_start = 1'b0;
    logic          burst_req = 1'b0;
    logic          write_req = 1'b0;
    logic          half_port = 1'b0;
    logic [AW-1:1] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          more_beats = 1'b0;
    logic [1:0]    wait_cfg = '0;
    logic          refuse_burst = 1'b0;
    logic          ack;
    logic          inhibit;
    logic [DW-1:0] rdata;

    always #5 clk = ~clk;

    burst_slave #(.AW(AW), .DW(DW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_start   (xfer_start),
        .burst_req    (burst_req),
        .write_req    (write_req),
        .half_port    (half_port),
        .addr         (addr),
        .wdata        (wdata),
        .more_beats   (more_beats),
        .wait_cfg     (wait_cfg),
        .refuse_burst (refuse_burst),
        .ack          (ack),
        .inhibit      (inhibit),
        .rdata        (rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] mm [0:15];
    bit m_busy = 0, m_wr = 0, m_bur = 0, m_half = 0, m_ref = 0, m_fin = 0;
    int m_wl = 0, m_idx = 0, m_base = 0, m_beats = 0, m_wcfg = 0;

    function automatic int m_waddr();
        return m_base * 4 + (m_half ? m_idx / 2 : m_idx);
    endfunction

    function automatic logic [31:0] m_read();
        logic [31:0] w;
        w = mm[m_waddr()];
        if (!m_half) return w;
        return (m_idx % 2 == 1) ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
            for (int i = 0; i < 16; i++) mm[i] = '0;
        end else if (!m_busy) begin
            if (xfer_start) begin
                m_busy  = 1;
                m_base  = int'(addr[AW-1:4]);
                m_half  = half_port;
                m_idx   = half_port ? int'(addr[3:1]) : int'(addr[3:2]);
                m_wr    = write_req;
                m_bur   = burst_req;
                m_ref   = refuse_burst;
                m_wcfg  = int'(wait_cfg);
                m_wl    = int'(wait_cfg);
                m_fin   = !more_beats;
                m_beats = 0;
            end
        end else if (m_wl == 0) begin
            if (m_wr) begin
                if (!m_half) mm[m_waddr()] = wdata;
                else if (m_idx % 2 == 1) mm[m_waddr()][31:16] = wdata[15:0];
                else mm[m_waddr()][15:0] = wdata[15:0];
            end
            if (!m_bur || m_ref || m_fin || !more_beats ||
                m_beats == (m_half ? 7 : 3)) begin
                m_busy = 0;
            end else begin
                m_idx   = (m_idx + 1) % (m_half ? 8 : 4);
                m_beats = m_beats + 1;
                m_wl    = m_wcfg;
            end
        end else begin
            m_wl = m_wl - 1;
            if (!more_beats) m_fin = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_ack;
            e_ack = m_busy && (m_wl == 0);
            chk(ack == e_ack, "R5 ack cycle vs model", 32'(ack), 32'(e_ack));
            chk(inhibit == (e_ack && m_bur && m_ref), "R10 inhibit vs model",
                32'(inhibit), 32'(e_ack && m_bur && m_ref));
            if (e_ack && !m_wr)
                chk(rdata == m_read(), "R6 read data vs model", rdata, m_read());
        end
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", wd);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- directed access task ----------------
    logic [31:0] rd_buf [0:15];

    task automatic run(input logic [AW-1:0] a, input bit w, input bit bur,
                       input bit hf, input int wt, input bit rf, input int k,
                       input int exp_n, input string tag, input bit poke,
                       input bit drop, input logic [31:0] seed);
        int cnt = 0;
        int lat = 0;
        int cyc = 0;
        bit saw_inh = 0;
        bit done = 0;
        xfer_start   = 1'b1;
        addr         = a[AW-1:1];
        write_req    = w;
        burst_req    = bur;
        half_port    = hf;
        wait_cfg     = wt[1:0];
        refuse_burst = rf;
        more_beats   = (k > 1);
        wdata        = '0;
        @(negedge clk);
        // scramble captured inputs (R2); optional stray start (R12)
        xfer_start   = poke;
        addr         = ~a[AW-1:1];
        write_req    = ~w;
        burst_req    = ~bur;
        half_port    = ~hf;
        wait_cfg     = ~wt[1:0];
        refuse_burst = ~rf;
        while (!done) begin
            cyc++;
            if (ack) begin
                cnt++;
                if (cnt == 1) lat = cyc;
                if (inhibit) saw_inh = 1;
                if (!w && cnt <= 16) rd_buf[cnt-1] = rdata;
                wdata = seed + 32'(cnt);
                more_beats = (cnt < k);
                if (cnt == k || inhibit || !bur || cnt == (hf ? 8 : 4) ||
                    (drop && cnt == 1)) done = 1;
            end else begin
                wdata = 32'hDEAD_0000 + 32'(cyc);
                more_beats = (cnt + 1 < k);
                if (drop && cyc == 1) more_beats = 1'b0;
            end
            if (cyc > 64) done = 1;
            xfer_start = 1'b0;
            if (!done) @(negedge clk);
        end
        chk(cnt == exp_n, {tag, " beat count"}, 32'(cnt), 32'(exp_n));
        chk(lat == wt + 1, "R5 R11 first ack latency", 32'(lat), 32'(wt + 1));
        chk(saw_inh == (bur && rf), "R10 inhibit presence",
            32'(saw_inh), 32'(bur && rf));
        @(negedge clk);
    endtask

    localparam logic [31:0] S1 = 32'h1234_5600;
    localparam logic [31:0] S2 = 32'hABCD_7700;

    initial begin
        repeat (3) @(negedge clk);
        chk(ack == 1'b0, "R1 reset ack", 32'(ack), 32'h0);
        chk(inhibit == 1'b0, "R1 reset inhibit", 32'(inhibit), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run(6'h04, 0, 1, 0, 0, 0, 4, 4, "R1 zero read", 0, 0, 0);
        chk(rd_buf[0] == 0, "R1 store cleared", rd_buf[0], 32'h0);

        run(6'h18, 1, 1, 0, 1, 0, 4, 4, "R3 wrap write", 0, 0, S1);
        run(6'h10, 0, 1, 0, 0, 0, 4, 4, "R3 wrap read", 0, 0, 0);
        chk(rd_buf[0] == S1 + 3, "R3 word0", rd_buf[0], S1 + 3);
        chk(rd_buf[1] == S1 + 4, "R3 word1", rd_buf[1], S1 + 4);
        chk(rd_buf[2] == S1 + 1, "R3 word2", rd_buf[2], S1 + 1);
        chk(rd_buf[3] == S1 + 2, "R3 word3", rd_buf[3], S1 + 2);

        run(6'h1A, 0, 1, 1, 0, 0, 8, 8, "R4 half read", 0, 0, 0);
        chk(rd_buf[0] == {16'h0, S1[31:16]}, "R4 hw5 upper half",
            rd_buf[0], {16'h0, S1[31:16]});
        chk(rd_buf[3] == {16'h0, 16'h5603}, "R4 hw0 after wrap",
            rd_buf[3], {16'h0, 16'h5603});

        run(6'h2E, 1, 1, 1, 2, 0, 3, 3, "R4 half write", 0, 0, S2);
        run(6'h20, 0, 0, 0, 0, 0, 1, 1, "R9 single read", 0, 0, 0);
        chk(rd_buf[0] == {16'h7703, 16'h7702}, "R4 halves merged",
            rd_buf[0], {16'h7703, 16'h7702});

        run(6'h30, 1, 1, 0, 2, 0, 2, 2, "R7 early stop write", 0, 0, 32'h5500_0000);
        run(6'h34, 0, 1, 0, 1, 0, 3, 3, "R7 early stop read", 0, 0, 0);
        run(6'h3C, 0, 1, 0, 2, 0, 4, 1, "R7 sticky drop", 0, 1, 0);
        run(6'h00, 0, 1, 0, 0, 0, 9, 4, "R8 word cap", 0, 0, 0);
        run(6'h08, 0, 1, 1, 0, 0, 12, 8, "R8 half cap", 0, 0, 0);
        run(6'h24, 1, 0, 0, 3, 0, 4, 1, "R9 single write", 0, 0, 32'h6600_0000);
        run(6'h28, 0, 1, 0, 1, 1, 4, 1, "R10 refused burst", 0, 0, 0);
        run(6'h28, 0, 0, 0, 0, 1, 4, 1, "R10 refuse on single", 0, 0, 0);
        run(6'h14, 0, 1, 0, 1, 0, 4, 4, "R12 R2 stray start", 1, 0, 0);
        run(6'h3C, 1, 1, 0, 0, 0, 4, 4, "R11 back to back a", 0, 0, 32'h7000_0000);
        run(6'h30, 0, 1, 0, 0, 0, 4, 4, "R11 back to back b", 0, 0, 0);
        chk(rd_buf[3] == 32'h7000_0001, "R11 data after back to back",
            rd_buf[3], 32'h7000_0001);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule